// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipeline. A pixel counter runs across each line, and a half-line counter runs across each frame. Three sync output sets compare those counters against programmable edge positions. Each set has one horizontal output and one vertical output. The vertical edges are programmed separately for the top and bottom field. A rectangular active-video window is decoded from a per-field start point and stop point. Each frame start sets an interrupt status bit, which tells software which field has begun.

All configuration goes through a 32-bit register bus. The bus has a single-cycle write strobe, word-aligned byte addresses and combinational read data. The generator can run freely as a timing master. As a slave, it returns its counters to the frame origin whenever an external sync input rises. A soft restart returns the counters to the frame origin on command.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 up to the line-length register value (address 0x04, bits 15:0) minus one and then returns to 0.
- R2: The frame-length register (address 0x08, bits 15:0) holds half-lines per frame. The half-line counter steps on the last pixel of a line and on pixel (line length / 2) - 1, and it returns to 0 after frame length minus one. The line number is the half-line count divided by two.
- R3: Mode register (0x00) bit 0 selects slave operation. In slave mode, a rising edge of `ext_sync` sampled at a clock edge puts both counters at 0 and the field at top for the next cycle, and it raises no frame event. In master mode, `ext_sync` has no effect.
- R4: A write to 0x0C with bit 0 set puts both counters at 0 and the field at top for the next cycle, without a frame event. Writes to 0x0C with bit 0 clear do nothing.
- R5: Each sync output is registered. Its next value is low when the compared position equals the word's bits 15:0. Otherwise it is high when the position equals bits 31:16. Otherwise it holds. Equal values therefore keep the output low.
- R6: Set k has its horizontal word at 0x40+16k, compared with the pixel count. Its top-field vertical word is at 0x44+16k and its bottom-field vertical word at 0x48+16k, both compared with the half-line count of the current field.
- R7: `active_o` is high while the line number is at or above the start line and below the stop line, and the pixel count is at or above the start pixel and below the stop pixel. The window words are top start 0x30, top stop 0x34, bottom start 0x38 and bottom stop 0x3C, each with the line in bits 31:16 and the pixel in bits 15:0.
- R8: At a frame wrap, the new field is the inverse of the current one when mode bit 1 (interlaced) is set, and top otherwise. `field_o` is 0 for top and 1 for bottom.
- R9: A frame wrap sets status bit 1 for a top field or bit 0 for a bottom field, whether or not the bit is masked. The status is read at 0x10. Writing ones to 0x14 clears those bits. A set and a clear in the same cycle leave the bit set.
- R10: Writing ones to 0x1C sets the matching mask bits, and writing ones to 0x20 clears them. Bits written as zero keep their value. The mask is read at 0x18.
- R11: `irq_o` is high exactly when some status bit and its mask bit are both set.
- R12: The configuration registers read back what was written, zero-extended. The addresses 0x0C, 0x14, 0x1C and 0x20 read as zero. After reset, the line length is 16, the frame length is 8 half-lines, and mode, mask, status, window and sync words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_sync | input | 1 | External frame sync used in slave mode |
| hsync_o | output | 3 | Horizontal sync output of each set |
| vsync_o | output | 3 | Vertical sync output of each set |
| active_o | output | 1 | Active-video window flag |
| field_o | output | 1 | Current field, 0 top, 1 bottom |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The hardest situation to create is a status-clear write that lands on the same clock edge as a frame wrap, because the wrap cycle depends on every earlier realignment and configuration write. The bench keeps its own cycle model of both counters. It waits until that model predicts a wrap on the next edge, then issues the clear there and reads the status back. Slave realignments and restarts are also injected at random points. In those cases, comparing every output on every cycle with the model catches off-by-one errors in the counter clearing and in the half-line stepping.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int POS_W  = 16;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        FIELD_TOP = 1'b0,
        FIELD_BOT = 1'b1
    } field_e;

    // upper half raises the output, lower half drops it
    typedef struct packed {
        pos_t on_at;
        pos_t off_at;
    } edge_pair_t;

    typedef struct packed {
        pos_t line;
        pos_t pix;
    } win_pt_t;

    localparam addr_t A_MODE   = 8'h00;
    localparam addr_t A_LLEN   = 8'h04;
    localparam addr_t A_FLEN   = 8'h08;
    localparam addr_t A_RSTRT  = 8'h0C;
    localparam addr_t A_ISTAT  = 8'h10;
    localparam addr_t A_ICLR   = 8'h14;
    localparam addr_t A_IMASK  = 8'h18;
    localparam addr_t A_MSET   = 8'h1C;
    localparam addr_t A_MCLR   = 8'h20;
    localparam addr_t A_WIN_TS = 8'h30;
    localparam addr_t A_WIN_TE = 8'h34;
    localparam addr_t A_WIN_BS = 8'h38;
    localparam addr_t A_WIN_BE = 8'h3C;
    localparam addr_t A_SYNC0  = 8'h40;
    localparam int    SYNC_STRIDE = 16;

    // slot 0 horizontal, 1 top-field vertical, 2 bottom-field vertical
    function automatic addr_t sync_addr(int set, int slot);
        return addr_t'(int'(A_SYNC0) + SYNC_STRIDE * set + 4 * slot);
    endfunction

    function automatic logic next_level(logic cur, pos_t pos, edge_pair_t ep);
        if (pos == ep.off_at)
            return 1'b0;
        else if (pos == ep.on_at)
            return 1'b1;
        return cur;
    endfunction

    function automatic logic in_window(pos_t line, pos_t pix, win_pt_t s, win_pt_t e);
        return (line >= s.line) && (line < e.line) && (pix >= s.pix) && (pix < e.pix);
    endfunction

endpackage

// File: rtl/rtg_counters.sv
module rtg_counters
    import raster_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pos_t   line_len,
    input  pos_t   frame_hl,
    input  logic   interlaced,
    input  logic   realign,
    output pos_t   px,
    output pos_t   hl,
    output field_e field,
    output logic   frame_ev,
    output field_e ev_field
);

    pos_t half;
    logic last_px, mid_px, hl_step, hl_last;

    always_comb begin
        half     = line_len >> 1;
        last_px  = (px == line_len - 1'b1);
        mid_px   = (half != '0) && (px == half - 1'b1);
        hl_step  = last_px || mid_px;
        hl_last  = (hl == frame_hl - 1'b1);
        frame_ev = hl_step && hl_last && !realign;
        ev_field = interlaced ? field_e'(~field) : FIELD_TOP;
    end

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            px    <= '0;
            hl    <= '0;
            field <= FIELD_TOP;
        end else begin
            px <= last_px ? '0 : px + 1'b1;
            if (hl_step)
                hl <= hl_last ? '0 : hl + 1'b1;
            if (frame_ev)
                field <= ev_field;
        end
    end

    // R1
    px_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!realign && px == line_len - 1'b1) |=> (px == '0));

    // R2
    hl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!realign && !hl_step) |=> $stable(hl));

    // R4
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        realign |=> (px == '0 && hl == '0 && field == FIELD_TOP));

endmodule

// File: rtl/rtg_edge_out.sv
module rtg_edge_out
    import raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pos_t       pos,
    input  edge_pair_t pair,
    output logic       lvl
);

    always_ff @(posedge clk) begin
        if (rst)
            lvl <= 1'b0;
        else
            lvl <= next_level(lvl, pos, pair);
    end

    // R5
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        (pos == pair.on_at && pos != pair.off_at) |=> lvl);

    // R5
    fall_chk: assert property (@(posedge clk) disable iff (rst)
        (pos == pair.off_at) |=> !lvl);

endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
    import raster_pkg::*;
#(
    parameter int   NSYNC     = 3,
    parameter pos_t LINE_DEF  = 16,
    parameter pos_t FRAME_DEF = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  addr_t                  bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    output logic [REG_W-1:0]       bus_rdata,
    input  logic                   frame_ev,
    input  field_e                 ev_field,
    output pos_t                   line_len,
    output pos_t                   frame_hl,
    output logic                   slave,
    output logic                   interlaced,
    output logic                   restart,
    output edge_pair_t [NSYNC-1:0] sync_h,
    output edge_pair_t [NSYNC-1:0] sync_tv,
    output edge_pair_t [NSYNC-1:0] sync_bv,
    output win_pt_t [1:0]          win_s,
    output win_pt_t [1:0]          win_e,
    output logic                   irq
);

    localparam int NIRQ = 2;

    logic [1:0]      mode_q;
    logic [NIRQ-1:0] stat_q, mask_q, ev_bits, clr_bits;
    logic            clr_hit, set_hit, mclr_hit;

    assign slave      = mode_q[0];
    assign interlaced = mode_q[1];
    assign restart    = bus_wr && (bus_addr == A_RSTRT) && bus_wdata[0];
    assign clr_hit    = bus_wr && (bus_addr == A_ICLR);
    assign set_hit    = bus_wr && (bus_addr == A_MSET);
    assign mclr_hit   = bus_wr && (bus_addr == A_MCLR);
    assign ev_bits    = !frame_ev ? '0 : (ev_field == FIELD_BOT) ? 2'b01 : 2'b10;
    assign clr_bits   = clr_hit ? bus_wdata[NIRQ-1:0] : '0;
    assign irq        = |(stat_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            line_len <= LINE_DEF;
            frame_hl <= FRAME_DEF;
            stat_q   <= '0;
            mask_q   <= '0;
            sync_h   <= '0;
            sync_tv  <= '0;
            sync_bv  <= '0;
            win_s    <= '0;
            win_e    <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | ev_bits;
            if (set_hit)
                mask_q <= mask_q | bus_wdata[NIRQ-1:0];
            else if (mclr_hit)
                mask_q <= mask_q & ~bus_wdata[NIRQ-1:0];
            if (bus_wr) begin
                case (bus_addr)
                    A_MODE:   mode_q   <= bus_wdata[1:0];
                    A_LLEN:   line_len <= bus_wdata[POS_W-1:0];
                    A_FLEN:   frame_hl <= bus_wdata[POS_W-1:0];
                    A_WIN_TS: win_s[0] <= win_pt_t'(bus_wdata);
                    A_WIN_TE: win_e[0] <= win_pt_t'(bus_wdata);
                    A_WIN_BS: win_s[1] <= win_pt_t'(bus_wdata);
                    A_WIN_BE: win_e[1] <= win_pt_t'(bus_wdata);
                    default: ;
                endcase
                for (int k = 0; k < NSYNC; k++) begin
                    if (bus_addr == sync_addr(k, 0)) sync_h[k]  <= edge_pair_t'(bus_wdata);
                    if (bus_addr == sync_addr(k, 1)) sync_tv[k] <= edge_pair_t'(bus_wdata);
                    if (bus_addr == sync_addr(k, 2)) sync_bv[k] <= edge_pair_t'(bus_wdata);
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:   bus_rdata = {30'b0, mode_q};
            A_LLEN:   bus_rdata = {16'b0, line_len};
            A_FLEN:   bus_rdata = {16'b0, frame_hl};
            A_ISTAT:  bus_rdata = {30'b0, stat_q};
            A_IMASK:  bus_rdata = {30'b0, mask_q};
            A_WIN_TS: bus_rdata = win_s[0];
            A_WIN_TE: bus_rdata = win_e[0];
            A_WIN_BS: bus_rdata = win_s[1];
            A_WIN_BE: bus_rdata = win_e[1];
            default: ;
        endcase
        for (int k = 0; k < NSYNC; k++) begin
            if (bus_addr == sync_addr(k, 0)) bus_rdata = sync_h[k];
            if (bus_addr == sync_addr(k, 1)) bus_rdata = sync_tv[k];
            if (bus_addr == sync_addr(k, 2)) bus_rdata = sync_bv[k];
        end
    end

    // R9
    stat_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_ev && ev_field == FIELD_TOP) |=> stat_q[1]);

    // R9
    stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && bus_wdata[0] && !(frame_ev && ev_field == FIELD_BOT)) |=> !stat_q[0]);

    // R10
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> ((mask_q & $past(bus_wdata[NIRQ-1:0])) == $past(bus_wdata[NIRQ-1:0])));

    // R10
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mclr_hit |=> ((mask_q & ~$past(bus_wdata[NIRQ-1:0])) == ($past(mask_q) & ~$past(bus_wdata[NIRQ-1:0]))));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int   NSYNC     = 3,
    parameter pos_t LINE_DEF  = 16,
    parameter pos_t FRAME_DEF = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             ext_sync,
    output logic [NSYNC-1:0] hsync_o,
    output logic [NSYNC-1:0] vsync_o,
    output logic             active_o,
    output logic             field_o,
    output logic             irq_o
);

    pos_t       line_len, frame_hl, px, hl;
    logic       slave, interlaced, restart, realign, ext_q, frame_ev;
    field_e     field, ev_field;
    edge_pair_t [NSYNC-1:0] sync_h, sync_tv, sync_bv;
    win_pt_t    [1:0]       win_s, win_e;
    win_pt_t    cur_s, cur_e;

    rtg_regs #(
        .NSYNC(NSYNC), .LINE_DEF(LINE_DEF), .FRAME_DEF(FRAME_DEF)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_ev(frame_ev), .ev_field(ev_field),
        .line_len(line_len), .frame_hl(frame_hl),
        .slave(slave), .interlaced(interlaced), .restart(restart),
        .sync_h(sync_h), .sync_tv(sync_tv), .sync_bv(sync_bv),
        .win_s(win_s), .win_e(win_e), .irq(irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ext_q <= 1'b0;
        else
            ext_q <= ext_sync;
    end

    assign realign = restart || (slave && ext_sync && !ext_q);

    rtg_counters u_cnt (
        .clk(clk), .rst(rst),
        .line_len(line_len), .frame_hl(frame_hl),
        .interlaced(interlaced), .realign(realign),
        .px(px), .hl(hl), .field(field),
        .frame_ev(frame_ev), .ev_field(ev_field)
    );

    for (genvar k = 0; k < NSYNC; k++) begin : g_sync
        edge_pair_t vpair;
        assign vpair = (field == FIELD_BOT) ? sync_bv[k] : sync_tv[k];

        rtg_edge_out u_h (
            .clk(clk), .rst(rst), .pos(px), .pair(sync_h[k]), .lvl(hsync_o[k])
        );
        rtg_edge_out u_v (
            .clk(clk), .rst(rst), .pos(hl), .pair(vpair), .lvl(vsync_o[k])
        );
    end

    assign cur_s    = (field == FIELD_BOT) ? win_s[1] : win_s[0];
    assign cur_e    = (field == FIELD_BOT) ? win_e[1] : win_e[0];
    assign active_o = in_window(hl >> 1, px, cur_s, cur_e);
    assign field_o  = field;

    // R3
    slave_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!slave && !restart && px != line_len - 1'b1) |=> (px == $past(px) + 1'b1));

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_sync = 1'b0;
    logic [NS-1:0] hsync_o, vsync_o;
    logic        active_o, field_o, irq_o;

    always #4 clk = ~clk;

    raster_timing_gen #(.NSYNC(NS)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_sync(ext_sync),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .active_o(active_o),
        .field_o(field_o), .irq_o(irq_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic chk_en = 1'b0;

    // bench model of the requirements
    logic [15:0] s_len, s_fhl, m_px, m_hl;
    logic [1:0]  s_mode, s_stat, s_mask;
    logic [31:0] s_h [NS], s_tv [NS], s_bv [NS], s_ws [2], s_we [2];
    logic        m_fld, m_ext_q;
    logic [NS-1:0] m_hs, m_vs;

    function automatic logic lvl_next(logic cur, logic [15:0] p, logic [31:0] w);
        if (p == w[15:0]) return 1'b0;
        if (p == w[31:16]) return 1'b1;
        return cur;
    endfunction

    function automatic logic step_now();
        logic [15:0] h;
        h = s_len >> 1;
        return (m_px == s_len - 16'd1) || (h != 0 && m_px == h - 16'd1);
    endfunction

    function automatic logic wrap_pred();
        return step_now() && (m_hl == s_fhl - 16'd1);
    endfunction

    function automatic logic act_model();
        logic [31:0] s, e;
        logic [15:0] ln;
        s = s_ws[m_fld];
        e = s_we[m_fld];
        ln = m_hl >> 1;
        return ln >= s[31:16] && ln < e[31:16] && m_px >= s[15:0] && m_px < e[15:0];
    endfunction

    always @(posedge clk) begin
        logic realign, wrap, step, nf;
        if (rst) begin
            s_len = 16; s_fhl = 8; s_mode = 0; s_stat = 0; s_mask = 0;
            for (int k = 0; k < NS; k++) begin s_h[k] = 0; s_tv[k] = 0; s_bv[k] = 0; end
            for (int k = 0; k < 2; k++) begin s_ws[k] = 0; s_we[k] = 0; end
            m_px = 0; m_hl = 0; m_fld = 0; m_ext_q = 0; m_hs = 0; m_vs = 0;
        end else begin
            realign = (bus_wr && bus_addr == 8'h0C && bus_wdata[0]) ||
                      (s_mode[0] && ext_sync && !m_ext_q);
            step = step_now();
            wrap = wrap_pred() && !realign;
            nf = s_mode[1] ? ~m_fld : 1'b0;
            for (int k = 0; k < NS; k++) begin
                m_hs[k] = lvl_next(m_hs[k], m_px, s_h[k]);
                m_vs[k] = lvl_next(m_vs[k], m_hl, m_fld ? s_bv[k] : s_tv[k]);
            end
            if (bus_wr && bus_addr == 8'h14) s_stat = s_stat & ~bus_wdata[1:0];
            if (wrap) s_stat = s_stat | (nf ? 2'b01 : 2'b10);
            if (realign) begin
                m_px = 0; m_hl = 0; m_fld = 0;
            end else begin
                if (step) m_hl = (m_hl == s_fhl - 16'd1) ? 16'd0 : m_hl + 16'd1;
                m_px = (m_px == s_len - 16'd1) ? 16'd0 : m_px + 16'd1;
                if (wrap) m_fld = nf;
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: s_mode = bus_wdata[1:0];
                    8'h04: s_len = bus_wdata[15:0];
                    8'h08: s_fhl = bus_wdata[15:0];
                    8'h1C: s_mask = s_mask | bus_wdata[1:0];
                    8'h20: s_mask = s_mask & ~bus_wdata[1:0];
                    8'h30: s_ws[0] = bus_wdata;
                    8'h34: s_we[0] = bus_wdata;
                    8'h38: s_ws[1] = bus_wdata;
                    8'h3C: s_we[1] = bus_wdata;
                    default: ;
                endcase
                for (int k = 0; k < NS; k++) begin
                    if (bus_addr == 8'(8'h40 + 16 * k)) s_h[k] = bus_wdata;
                    if (bus_addr == 8'(8'h44 + 16 * k)) s_tv[k] = bus_wdata;
                    if (bus_addr == 8'(8'h48 + 16 * k)) s_bv[k] = bus_wdata;
                end
            end
            m_ext_q = ext_sync;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 30)
                $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            chk(hsync_o == m_hs, "R1 R3 R4 R5 R6 hsync", 32'(hsync_o), 32'(m_hs));
            chk(vsync_o == m_vs, "R2 R5 R6 vsync", 32'(vsync_o), 32'(m_vs));
            chk(active_o == act_model(), "R7 active", 32'(active_o), 32'(act_model()));
            chk(field_o == m_fld, "R8 field", 32'(field_o), 32'(m_fld));
            chk(irq_o == |(s_stat & s_mask), "R11 irq", 32'(irq_o), 32'(|(s_stat & s_mask)));
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rand_cfg();
        logic [15:0] len, fhl;
        len = 16'(6 + $urandom % 30);
        fhl = 16'(4 + $urandom % 16);
        wr(8'h04, {16'h0, len});
        wr(8'h08, {16'h0, fhl});
        wr(8'h00, 32'($urandom % 4));
        for (int k = 0; k < NS; k++) begin
            logic [15:0] a, b;
            a = 16'($urandom % len);
            b = ($urandom % 5 == 0) ? a : 16'($urandom % len);
            wr(8'(8'h40 + 16 * k), {a, b});
            a = 16'($urandom % fhl);
            b = 16'($urandom % fhl);
            wr(8'(8'h44 + 16 * k), {a, b});
            wr(8'(8'h48 + 16 * k), {b, a});
        end
        wr(8'h30, {16'($urandom % 3), 16'($urandom % 4)});
        wr(8'h34, {16'(1 + $urandom % 10), 16'(2 + $urandom % len)});
        wr(8'h38, {16'($urandom % 3), 16'($urandom % 4)});
        wr(8'h3C, {16'(1 + $urandom % 10), 16'(2 + $urandom % len)});
        wr(8'h0C, 32'h1);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;

        // reset state
        chk(hsync_o == 0 && vsync_o == 0, "R5 reset sync low", 32'({hsync_o, vsync_o}), 0);
        rd(8'h04, d); chk(d == 16, "R12 reset line length", d, 16);
        rd(8'h08, d); chk(d == 8, "R12 reset frame length", d, 8);
        rd(8'h18, d); chk(d == 0, "R12 reset mask", d, 0);
        rd(8'h00, d); chk(d == 0, "R12 reset mode", d, 0);

        // write-only aliases read zero
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); chk(d == 0, "R12 clear alias reads zero", d, 0);
        wr(8'h0C, 32'h0);
        rd(8'h0C, d); chk(d == 0, "R12 restart reads zero", d, 0);
        rd(8'h1C, d); chk(d == 0, "R12 set alias reads zero", d, 0);
        rd(8'h20, d); chk(d == 0, "R12 mask clear alias reads zero", d, 0);

        // mask bit set and clear only touch ones
        wr(8'h1C, 32'h1); rd(8'h18, d); chk(d == 1, "R10 mask set bit0", d, 1);
        wr(8'h1C, 32'h2); rd(8'h18, d); chk(d == 3, "R10 mask set bit1 keeps bit0", d, 3);
        wr(8'h20, 32'h1); rd(8'h18, d); chk(d == 2, "R10 mask clear bit0 keeps bit1", d, 2);
        wr(8'h20, 32'h2);

        // progressive: only the top event fires, status set while masked
        wr(8'h04, 32'd10);
        wr(8'h08, 32'd6);
        wr(8'h40, {16'd2, 16'd5});
        wr(8'h44, {16'd1, 16'd3});
        wr(8'h30, {16'd0, 16'd1});
        wr(8'h34, {16'd2, 16'd8});
        rd(8'h40, d); chk(d == {16'd2, 16'd5}, "R12 sync word readback", d, {16'd2, 16'd5});
        wr(8'h0C, 32'h1);
        wr(8'h14, 32'h3);
        idle(200);
        rd(8'h10, d); chk(d == 32'h2, "R9 progressive only top status", d, 2);
        chk(irq_o == 1'b0, "R11 masked status gives no irq", 32'(irq_o), 0);
        wr(8'h1C, 32'h2);
        @(negedge clk); chk(irq_o == 1'b1, "R11 unmasked top status raises irq", 32'(irq_o), 1);

        // clear on the very wrap edge: the set wins
        @(negedge clk);
        while (!wrap_pred()) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h3;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h10, d); chk(d == 32'h2, "R9 set wins over same-cycle clear", d, 2);
        wr(8'h14, 32'h2);
        rd(8'h10, d); chk(d == 32'h0, "R9 write-one clear", d, 0);

        // interlaced: both field events appear
        wr(8'h00, 32'h2);
        wr(8'h0C, 32'h1);
        idle(150);
        rd(8'h10, d); chk(d == 32'h3, "R8 interlaced alternates fields", d, 3);
        wr(8'h14, 32'h3);

        // slave with periodic external sync
        wr(8'h00, 32'h1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            ext_sync = (i % 23) < 2;
        end
        ext_sync = 1'b0;
        rd(8'h00, d); chk(d == 1, "R3 slave mode readback", d, 1);

        // restart with bit 0 clear has no effect (checked per cycle), then random
        wr(8'h0C, 32'h2);
        for (int c = 0; c < 25; c++) begin
            rand_cfg();
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                ext_sync = ($urandom % 40) == 0;
                if ($urandom % 150 == 0) begin
                    bus_wr = 1'b1;
                    bus_addr = ($urandom % 2) ? 8'h14 : 8'h1C;
                    bus_wdata = 32'($urandom % 4);
                    @(negedge clk);
                    bus_wr = 1'b0;
                end
            end
            ext_sync = 1'b0;
            rd(8'h10, d); chk(d == 32'(s_stat), "R9 status readback", d, 32'(s_stat));
            wr(8'h14, 32'h3);
        end

        chk_en = 1'b0;
        summary();
        $finish;
    end

endmodule